// File: doc/BRIEF.md
# Low-pass delta-sigma modulator

This block turns a stream of signed multi-bit samples into a one-bit stream whose local average follows the input. It is used after an interpolator has raised the sample rate, at an oversampling ratio of about 128. Each strobed input sample produces exactly one output bit. The quantization error is fed back through a chain of integrators, so the noise it adds is pushed away from the band near DC and the low-frequency content of the bitstream stays close to the input.

A parameter selects either a single integrator (first order) or two cascaded integrators (second order). The second-order loop shapes the noise more strongly. The quantizer is the sign of the last integrator. The fed-back value is plus full scale for a 1 and minus full scale for a 0, with full scale FS = 2^(IN_W-1). The integrators carry guard bits above the input width and clamp at their limits rather than wrapping. The block has no state machine: its only sequential behaviour is the integrator update on each strobe. The loop order is a build-time choice between two variants, first order and second order.

Top module: `dsm_lowpass`

## Requirements
- R1: While reset is asserted, out_vld and out_bit are 0 and every integrator is zero, so the first strobe after reset produces out_bit = 1.
- R2: On a clock where in_vld is 0, no integrator changes, out_bit keeps its value and out_vld is 0 on the next clock.
- R3: out_vld equals in_vld delayed by one clock. The bit for a strobe appears on out_bit in that same delayed clock.
- R4: With ORDER = 1, each strobe sets out_bit to 1 exactly when integrator i1 is non-negative before the update. i1 then becomes sat(i1 + x - v), where v = +FS for a 1 and -FS for a 0.
- R5: With ORDER = 2, out_bit is 1 exactly when i2 is non-negative before the update. Both integrators update from their old values: i1 becomes sat(i1 + x - v) and i2 becomes sat(i2 + i1 - 2v).
- R6: Integrators are ACC_W = IN_W + GUARD bits wide, two's complement, with GUARD at least 2. A result outside [-2^(ACC_W-1), 2^(ACC_W-1)-1] clamps to the nearer limit instead of wrapping, so a single update of i1 never moves it by more than 2*FS.
- R7: For a constant input x with |x| <= FS/2, the 1024 bits that follow a reset satisfy |(2*ones - 1024)*FS - 1024*x| <= 10*FS in both loop orders, where ones is the number of 1 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Sample strobe at the oversampled rate |
| in_sample | input | IN_W | Signed two's-complement input sample |
| out_vld | output | 1 | Marks a clock that carries a new output bit |
| out_bit | output | 1 | One-bit modulator output (1 = +FS, 0 = -FS) |

## Verification
The assertions rely on reset being applied before the first strobe. They place no limit on the input code or on the pattern of in_vld, because every two's-complement value must clamp cleanly. The stimulus sweeps every input code of a 6-bit configuration, including the most negative one that drives the second-order loop into clamping. It gaps the strobe every fourth sample so that the hold behaviour is exercised. It resets before each code, so the mean-tracking bound is measured from zero state, and the bound is checked only for inputs within half of full scale.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
    // Quantizer decision: sign of the last integrator.
    typedef enum logic {
        DEC_NEG = 1'b0,
        DEC_POS = 1'b1
    } dsm_dec_e;

    // Smallest headroom above the input width the integrators may use.
    localparam int DSM_MIN_GUARD = 2;
endpackage

// File: rtl/dsm_integrator.sv
module dsm_integrator #(
    parameter int ACC_W    = 20,
    parameter int FB_SHIFT = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic signed [ACC_W-1:0] feed_in,
    input  logic signed [ACC_W-1:0] fb_in,
    output logic signed [ACC_W-1:0] acc_q
);
    localparam int SUM_W = ACC_W + 3;
    localparam logic signed [SUM_W-1:0] MAXV = SUM_W'(2**(ACC_W-1) - 1);
    localparam logic signed [SUM_W-1:0] MINV = -MAXV - SUM_W'(1);

    logic signed [SUM_W-1:0] sum_w;
    logic signed [ACC_W-1:0] acc_nxt;

    // Wide sum, then clamp to the register range.
    always_comb begin
        sum_w = SUM_W'(acc_q) + SUM_W'(feed_in) - (SUM_W'(fb_in) <<< FB_SHIFT);
        if (sum_w > MAXV) begin
            acc_nxt = MAXV[ACC_W-1:0];
        end else if (sum_w < MINV) begin
            acc_nxt = MINV[ACC_W-1:0];
        end else begin
            acc_nxt = sum_w[ACC_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (en) begin
            acc_q <= acc_nxt;
        end
    end
endmodule

// File: rtl/dsm_quantizer.sv
module dsm_quantizer
    import dsm_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int ACC_W = 20
) (
    input  logic signed [ACC_W-1:0] last_int,
    output dsm_dec_e                dec,
    output logic signed [ACC_W-1:0] fb_val
);
    localparam logic signed [ACC_W-1:0] FS_POS = ACC_W'(2**(IN_W-1));
    localparam logic signed [ACC_W-1:0] FS_NEG = -FS_POS;

    always_comb begin
        dec    = last_int[ACC_W-1] ? DEC_NEG : DEC_POS;
        fb_val = FS_NEG;
        unique case (dec)
            DEC_POS: fb_val = FS_POS;
            DEC_NEG: fb_val = FS_NEG;
        endcase
    end
endmodule

// File: rtl/dsm_lowpass.sv
module dsm_lowpass
    import dsm_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int ORDER = 2,
    parameter int GUARD = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_vld,
    input  logic signed [IN_W-1:0] in_sample,
    output logic                   out_vld,
    output logic                   out_bit
);
    localparam int GUARD_EFF = (GUARD < DSM_MIN_GUARD) ? DSM_MIN_GUARD : GUARD;
    localparam int ACC_W     = IN_W + GUARD_EFF;

    logic signed [ACC_W-1:0] x_ext;
    logic signed [ACC_W-1:0] i1_q;
    logic signed [ACC_W-1:0] last_q;
    logic signed [ACC_W-1:0] fb_val;
    dsm_dec_e                dec;

    assign x_ext = ACC_W'(in_sample);

    dsm_quantizer #(.IN_W(IN_W), .ACC_W(ACC_W)) u_quant (
        .last_int (last_q),
        .dec      (dec),
        .fb_val   (fb_val)
    );

    dsm_integrator #(.ACC_W(ACC_W), .FB_SHIFT(0)) u_int1 (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (in_vld),
        .feed_in (x_ext),
        .fb_in   (fb_val),
        .acc_q   (i1_q)
    );

    if (ORDER == 1) begin : g_first
        assign last_q = i1_q;
    end else begin : g_second
        logic signed [ACC_W-1:0] i2_q;
        // Second stage takes the old i1 and twice the feedback.
        dsm_integrator #(.ACC_W(ACC_W), .FB_SHIFT(1)) u_int2 (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (in_vld),
            .feed_in (i1_q),
            .fb_in   (fb_val),
            .acc_q   (i2_q)
        );
        assign last_q = i2_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_bit <= 1'b0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                out_bit <= (dec == DEC_POS);
            end
        end
    end
endmodule

// File: rtl/dsm_lowpass_chk.sv
module dsm_lowpass_chk #(
    parameter int IN_W  = 16,
    parameter int ACC_W = 20
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_vld,
    input logic                    out_vld,
    input logic                    out_bit,
    input logic signed [ACC_W-1:0] int1,
    input logic signed [ACC_W-1:0] last_int
);
    localparam int W2 = ACC_W + 2;
    localparam logic signed [W2-1:0] STEP_MAX = W2'(2**IN_W);

    logic signed [ACC_W-1:0] i1_prev;
    logic signed [W2-1:0]    i1_step;

    always_ff @(posedge clk) i1_prev <= int1;
    assign i1_step = W2'(int1) - W2'(i1_prev);

    // R3
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);
    // R3
    vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);
    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> ($stable(out_bit) && $stable(int1) && $stable(last_int)));
    // R6
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> ((i1_step <= STEP_MAX) && (i1_step >= -STEP_MAX)));
    // R4
    decision_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> (out_bit == !$past(last_int[ACC_W-1])));
endmodule

bind dsm_lowpass dsm_lowpass_chk #(.IN_W(IN_W), .ACC_W(ACC_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (in_vld),
    .out_vld  (out_vld),
    .out_bit  (out_bit),
    .int1     (i1_q),
    .last_int (last_q)
);

// File: tb/dsm_lowpass_tb_top.sv
`timescale 1ns/1ps
module dsm_lowpass_tb_top;
    localparam int IN_W  = 6;
    localparam int GUARD = 4;
    localparam int ACC_W = IN_W + GUARD;
    localparam int FS    = 2**(IN_W-1);
    localparam int AMAX  = 2**(ACC_W-1) - 1;
    localparam int AMIN  = -(2**(ACC_W-1));
    localparam int NS    = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_vld = 1'b0;
    logic signed [IN_W-1:0] in_sample = '0;
    logic o2_vld, o2_bit, o1_vld, o1_bit;

    int n_chk = 0;
    int n_fail = 0;
    int m1a, m1b, m2b;
    int ones1, ones2;
    bit first_strobe;

    always #2.5 clk = ~clk;

    dsm_lowpass #(.IN_W(IN_W), .ORDER(2), .GUARD(GUARD)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_sample(in_sample),
        .out_vld(o2_vld), .out_bit(o2_bit)
    );

    dsm_lowpass #(.IN_W(IN_W), .ORDER(1), .GUARD(GUARD)) dut_o1_i (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_sample(in_sample),
        .out_vld(o1_vld), .out_bit(o1_bit)
    );

    function automatic int clampv(int v);
        if (v > AMAX) return AMAX;
        if (v < AMIN) return AMIN;
        return v;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // R1: reset state, model cleared
    task automatic do_reset();
        rst_n = 1'b0;
        in_vld = 1'b0;
        repeat (2) @(negedge clk);
        chk(o2_vld == 0 && o2_bit == 0, "R1 reset outputs order2", {o2_vld, o2_bit}, 0);
        chk(o1_vld == 0 && o1_bit == 0, "R1 reset outputs order1", {o1_vld, o1_bit}, 0);
        rst_n = 1'b1;
        m1a = 0; m1b = 0; m2b = 0;
        first_strobe = 1'b1;
        @(negedge clk);
    endtask

    task automatic cyc(bit vld, int x);
        bit e1, e2, h1, h2, clipped;
        int v1, v2, n1, n1b, n2b;
        string t1, t2;
        h1 = o1_bit;
        h2 = o2_bit;
        e1 = 1'b0; e2 = 1'b0;
        t1 = "R4 order1 bit";
        t2 = "R5 order2 bit";
        in_vld = vld;
        in_sample = IN_W'(x);
        if (vld) begin
            e1 = (m1a >= 0);
            v1 = e1 ? FS : -FS;
            n1 = clampv(m1a + x - v1);
            e2 = (m2b >= 0);
            v2 = e2 ? FS : -FS;
            n1b = clampv(m1b + x - v2);
            n2b = clampv(m2b + m1b - 2 * v2);
            clipped = (n1b != m1b + x - v2) || (n2b != m2b + m1b - 2 * v2);
            if (clipped) t2 = "R6 clamped order2 bit";
            if (first_strobe) begin
                t1 = "R1 first bit order1";
                t2 = "R1 first bit order2";
            end
            m1a = n1; m1b = n1b; m2b = n2b;
            first_strobe = 1'b0;
        end
        @(negedge clk);
        chk(o2_vld == vld, "R3 out_vld order2", o2_vld, vld);
        chk(o1_vld == vld, "R3 out_vld order1", o1_vld, vld);
        if (vld) begin
            chk(o2_bit == e2, t2, o2_bit, e2);
            chk(o1_bit == e1, t1, o1_bit, e1);
            ones1 += o1_bit;
            ones2 += o2_bit;
        end else begin
            chk(o2_bit == h2, "R2 hold order2", o2_bit, h2);
            chk(o1_bit == h1, "R2 hold order1", o1_bit, h1);
        end
    endtask

    task automatic run_code(int x);
        int err1, err2;
        do_reset();
        ones1 = 0;
        ones2 = 0;
        for (int s = 0; s < NS; s++) begin
            if (s % 4 == 3) cyc(1'b0, x);
            cyc(1'b1, x);
        end
        if (x <= FS / 2 && x >= -FS / 2) begin
            err1 = (2 * ones1 - NS) * FS - NS * x;
            err2 = (2 * ones2 - NS) * FS - NS * x;
            chk(err1 <= 10 * FS && err1 >= -10 * FS, "R7 mean order1", err1, 0);
            chk(err2 <= 10 * FS && err2 >= -10 * FS, "R7 mean order2", err2, 0);
        end
    endtask

    initial begin
        @(negedge clk);
        for (int x = -FS; x < FS; x++) begin
            run_code(x);
        end
        summary();
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end
endmodule